// File: doc/BRIEF.md
# Multi-Source Trigger Qualifier

This block turns a chosen trigger source into the run enable of a waveform sequencer, with one qualifier per output channel. Each channel picks its own source from a front-panel input, six backplane trigger lines, a star trigger line and a software trigger. It also picks how that source is read. In level mode the channel runs while the source is active. In toggle mode each qualifying edge flips the channel between running and stopped. In continuous mode a qualifying edge starts the channel, and it keeps running until software removes the lock.

A single control byte is written per channel. Its low nibble picks the source and its high nibble picks the mode. A shared software-trigger register holds one level bit per channel. A status word reports those software bits beside the synchronized level of the hardware source that each channel has selected. The external inputs are asynchronous and pass through a two-stage synchronizer before any decision is made. The sequencer's lock bit gates everything: without it, a channel never runs.

Top module: `trig_qual_top`

## Requirements
- R1: The low nibble of a channel's control byte selects the source: 0 front panel, 1 to 6 backplane lines 0 to 5, 7 star trigger, 8 software trigger.
- R2: The high nibble selects the mode: 0 active-high level, 1 active-low level, 2 rising-edge toggle, 3 falling-edge toggle, 6 rising-edge continuous, 7 falling-edge continuous.
- R3: In a level mode, a locked channel's run output follows the polarity-corrected source one clock after the qualifier sees it, and it drops as soon as the source goes inactive.
- R4: In a toggle mode, each qualifying edge inverts run. An edge of the opposite direction has no effect.
- R5: In a continuous mode, a qualifying edge sets run. Run then stays set through further edges and through the source returning inactive, until the lock drops.
- R6: When a channel's lock input is low, its run output is 0 from the next clock edge. A later lock with no new qualifying edge does not restart an edge mode.
- R7: A write to the software-trigger register stores bit 0 as channel A's software level and bit 1 as channel B's software level, so 0x03 triggers both at once. That level is source 8.
- R8: Status bits [1:0] are the software levels of A and B. Bits [3:2] are the synchronized raw level of the hardware source selected by A and B, reading 0 when the channel selects software or a reserved code.
- R9: Reserved source codes 9 to 15 and reserved mode codes 4, 5 and 8 to 15 never set run, whatever the inputs do.
- R10: A change on an external input shows in status after two clock edges and on run after the third. A software write shows on run on the edge after the write.
- R11: A control write clears that channel's run at the write edge. A source that is already active when the write lands does not count as an edge.
- R12: After reset, run and status are 0, and both control bytes read as active-high level on the front panel.
- R13: Each channel's control, edge history and run state are independent of the other channel's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| front_in | input | 1 | Front-panel trigger, asynchronous |
| bp_in | input | 6 | Backplane trigger lines 0 to 5, asynchronous |
| star_in | input | 1 | Star trigger, asynchronous |
| ctrl_wr | input | 2 | Control byte write strobe per channel (bit 0 = A) |
| ctrl_wdata | input | 8 | Control byte: [3:0] source, [7:4] mode |
| sw_wr | input | 1 | Software-trigger register write strobe |
| sw_wdata | input | 2 | Software trigger levels (bit 0 = A, bit 1 = B) |
| lock | input | 2 | Lock bit from the sequencer, per channel |
| run | output | 2 | Run enable to the sequencer, per channel |
| trig_status | output | 4 | {hw B, hw A, sw B, sw A} trigger status |

## Verification
Several rules are checked on every clock by properties: the lock gating, a control write clearing run, the level modes following the qualified source, a toggle flipping on each detected edge, continuous mode holding once set, reserved codes keeping run low, and the software status tracking each write. Other behaviour only shows across a whole scenario, so the bench's scenarios cover it. This includes the decode of each nibble onto real pins, the input latency through the synchronizer, an opposite-direction edge being ignored, a relock not restarting an edge mode, and an already-active source not counting as an edge after a control write.

// File: rtl/trq_pkg.sv
`timescale 1ns/1ps
package trq_pkg;

  typedef enum logic [1:0] {
    KIND_OFF    = 2'd0,
    KIND_LEVEL  = 2'd1,
    KIND_TOGGLE = 2'd2,
    KIND_CONT   = 2'd3
  } run_kind_e;

  typedef struct packed {
    run_kind_e kind;
    logic      invert;
  } mode_t;

  // High nibble of the control byte -> behaviour; bit 0 selects inverted sense
  function automatic mode_t mode_decode(input logic [3:0] code);
    mode_t m;
    m.invert = code[0];
    case (code)
      4'h0, 4'h1: m.kind = KIND_LEVEL;
      4'h2, 4'h3: m.kind = KIND_TOGGLE;
      4'h6, 4'h7: m.kind = KIND_CONT;
      default:    m.kind = KIND_OFF;
    endcase
    return m;
  endfunction

  // Next run value from the mode, the qualified level and a detected edge
  function automatic logic run_next(input run_kind_e kind, input logic act,
                                    input logic edge_hit, input logic cur);
    case (kind)
      KIND_LEVEL:  return act;
      KIND_TOGGLE: return cur ^ edge_hit;
      KIND_CONT:   return cur | edge_hit;
      default:     return 1'b0;
    endcase
  endfunction

  // Picks one line of a 16-entry source vector; unused entries read 0
  function automatic logic pick_source(input logic [15:0] srcs, input logic [3:0] code);
    return srcs[code];
  endfunction

endpackage

// File: rtl/trq_sync.sv
`timescale 1ns/1ps
module trq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)      stg[s] <= '0;
      else if (s == 0) stg[s] <= d;
      else             stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/trq_chan.sv
`timescale 1ns/1ps
module trq_chan
  import trq_pkg::*;
#(
  parameter int NSRC    = 9,
  parameter int SW_CODE = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_we,
  input  logic [7:0]      ctrl_wdata,
  input  logic [NSRC-1:0] src_vec,
  input  logic            lock,
  output logic            run,
  output logic            act,
  output logic            edge_hit,
  output logic            hw_level,
  output run_kind_e       kind
);
  localparam logic [4:0] NSRC_W = 5'(NSRC);
  localparam logic [3:0] SW_W   = 4'(SW_CODE);

  logic [7:0]  ctrl_q;
  logic        prev_act;
  mode_t       mode;
  logic [3:0]  src_code;
  logic        src_ok;
  logic        cur;
  logic [15:0] src_pad;

  assign src_code = ctrl_q[3:0];
  assign mode     = mode_decode(ctrl_q[7:4]);
  assign kind     = mode.kind;
  assign src_pad  = {{(16-NSRC){1'b0}}, src_vec};
  assign src_ok   = ({1'b0, src_code} < NSRC_W);
  assign cur      = pick_source(src_pad, src_code);

  // Polarity-corrected level of the chosen source; reserved codes stay idle
  assign act      = src_ok & (cur ^ mode.invert);
  assign edge_hit = act & ~prev_act;
  assign hw_level = src_ok & (src_code != SW_W) & cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= 8'h00;
      prev_act <= 1'b0;
      run      <= 1'b0;
    end else if (ctrl_we) begin
      ctrl_q   <= ctrl_wdata;
      prev_act <= 1'b1;   // an already active source is not an edge
      run      <= 1'b0;
    end else begin
      prev_act <= act;
      run      <= lock ? run_next(mode.kind, act, edge_hit, run) : 1'b0;
    end
  end
endmodule

// File: rtl/trig_qual_top.sv
`timescale 1ns/1ps
module trig_qual_top
  import trq_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int NUM_BP      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                front_in,
  input  logic [NUM_BP-1:0]   bp_in,
  input  logic                star_in,
  input  logic [NUM_CH-1:0]   ctrl_wr,
  input  logic [7:0]          ctrl_wdata,
  input  logic                sw_wr,
  input  logic [NUM_CH-1:0]   sw_wdata,
  input  logic [NUM_CH-1:0]   lock,
  output logic [NUM_CH-1:0]   run,
  output logic [2*NUM_CH-1:0] trig_status
);
  localparam int NEXT    = NUM_BP + 2;   // front, backplane lines, star
  localparam int NSRC    = NEXT + 1;     // plus software
  localparam int SW_CODE = NEXT;

  logic [NEXT-1:0]     ext_raw;
  logic [NEXT-1:0]     ext_sync;
  logic [NUM_CH-1:0]   sw_q;
  logic [NUM_CH-1:0]   hw_lvl;

  // Named internal events for the checker
  logic [NUM_CH-1:0]   ch_act;
  logic [NUM_CH-1:0]   ch_edge;
  logic [2*NUM_CH-1:0] ch_kind;

  assign ext_raw = {star_in, bp_in, front_in};

  trq_sync #(.W(NEXT), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ext_raw),
    .q     (ext_sync)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     sw_q <= '0;
    else if (sw_wr) sw_q <= sw_wdata;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    run_kind_e k;
    trq_chan #(.NSRC(NSRC), .SW_CODE(SW_CODE)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_we    (ctrl_wr[c]),
      .ctrl_wdata (ctrl_wdata),
      .src_vec    ({sw_q[c], ext_sync}),
      .lock       (lock[c]),
      .run        (run[c]),
      .act        (ch_act[c]),
      .edge_hit   (ch_edge[c]),
      .hw_level   (hw_lvl[c]),
      .kind       (k)
    );
    assign ch_kind[2*c +: 2] = k;
  end

  assign trig_status = {hw_lvl, sw_q};
endmodule

// File: rtl/trq_chk.sv
`timescale 1ns/1ps
module trq_chk
  import trq_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_CH-1:0]   lock,
  input logic [NUM_CH-1:0]   ctrl_wr,
  input logic                sw_wr,
  input logic [NUM_CH-1:0]   sw_wdata,
  input logic [NUM_CH-1:0]   run,
  input logic [NUM_CH-1:0]   sw_status,
  input logic [NUM_CH-1:0]   ch_act,
  input logic [NUM_CH-1:0]   ch_edge,
  input logic [2*NUM_CH-1:0] ch_kind
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ck
    // R6
    lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lock[c] |=> !run[c]);
    // R11
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr[c] |=> !run[c]);
    // R3
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock[c] && !ctrl_wr[c] && ch_kind[2*c +: 2] == KIND_LEVEL) |=> (run[c] == $past(ch_act[c])));
    // R4
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock[c] && !ctrl_wr[c] && ch_kind[2*c +: 2] == KIND_TOGGLE && ch_edge[c]) |=> (run[c] != $past(run[c])));
    // R5
    cont_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock[c] && !ctrl_wr[c] && ch_kind[2*c +: 2] == KIND_CONT && run[c]) |=> run[c]);
    // R9
    reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_wr[c] && ch_kind[2*c +: 2] == KIND_OFF) |=> !run[c]);
  end

  // R7
  sw_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> (sw_status == $past(sw_wdata)));
endmodule

bind trig_qual_top trq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lock      (lock),
  .ctrl_wr   (ctrl_wr),
  .sw_wr     (sw_wr),
  .sw_wdata  (sw_wdata),
  .run       (run),
  .sw_status (trig_status[NUM_CH-1:0]),
  .ch_act    (ch_act),
  .ch_edge   (ch_edge),
  .ch_kind   (ch_kind)
);

// File: tb/sim_trig_qual_top.sv
`timescale 1ns/1ps
module sim_trig_qual_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       front_in;
  logic [5:0] bp_in;
  logic       star_in;
  logic [1:0] ctrl_wr;
  logic [7:0] ctrl_wdata;
  logic       sw_wr;
  logic [1:0] sw_wdata;
  logic [1:0] lock;
  logic [1:0] run;
  logic [3:0] trig_status;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    string      tag;
    logic [1:0] run;
    logic [3:0] st;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  trig_qual_top u0 (
    .clk(clk), .rst_n(rst_n), .front_in(front_in), .bp_in(bp_in),
    .star_in(star_in), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .lock(lock), .run(run),
    .trig_status(trig_status)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ctrl(input int ch, input logic [7:0] v);
    ctrl_wdata  = v;
    ctrl_wr[ch] = 1'b1;
    step(1);
    ctrl_wr     = 2'b00;
  endtask

  task automatic wr_sw(input logic [1:0] v);
    sw_wdata = v;
    sw_wr    = 1'b1;
    step(1);
    sw_wr    = 1'b0;
  endtask

  // Driver side: push the expected outputs for this cycle
  task automatic expect_out(input string tag, input logic [1:0] r, input logic [3:0] s);
    exp_t e;
    e.tag = tag; e.run = r; e.st = s;
    sb.push_back(e);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (run !== e.run) begin
          errors++;
          $display("FAIL %s run=%b expected %b", e.tag, run, e.run);
        end
        checks++;
        if (trig_status !== e.st) begin
          errors++;
          $display("FAIL %s status=%b expected %b", e.tag, trig_status, e.st);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; front_in = 1'b0; bp_in = '0; star_in = 1'b0;
    ctrl_wr = '0; ctrl_wdata = '0; sw_wr = 1'b0; sw_wdata = '0; lock = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    expect_out("R12 reset", 2'b00, 4'b0000);
    lock = 2'b11;

    // R1 R2 R3: A front active-high level, B backplane line 1 active-low level
    wr_ctrl(0, 8'h00);
    wr_ctrl(1, 8'h12);
    step(1);
    expect_out("R3 neg level idle input", 2'b10, 4'b0000);
    front_in = 1'b1;
    step(2);
    expect_out("R10 status after two edges", 2'b10, 4'b0100);
    step(1);
    expect_out("R10 R3 run after third edge", 2'b11, 4'b0100);
    front_in = 1'b0;
    step(3);
    expect_out("R3 level drop", 2'b10, 4'b0000);
    bp_in[1] = 1'b1;
    step(3);
    expect_out("R3 R8 neg level inactive", 2'b00, 4'b1000);

    // R4: rising-edge toggle on front
    wr_ctrl(0, 8'h20);
    front_in = 1'b1;
    step(3);
    expect_out("R4 toggle start", 2'b01, 4'b1100);
    front_in = 1'b0;
    step(3);
    expect_out("R4 toggle holds on fall", 2'b01, 4'b1000);
    front_in = 1'b1;
    step(3);
    expect_out("R4 toggle stop", 2'b00, 4'b1100);
    front_in = 1'b0;
    step(3);

    // R4 R1: falling-edge toggle on backplane line 0 (code 1)
    wr_ctrl(0, 8'h31);
    bp_in[0] = 1'b1;
    step(3);
    expect_out("R4 rising ignored in falling mode", 2'b00, 4'b1100);
    bp_in[0] = 1'b0;
    step(3);
    expect_out("R4 falling edge starts", 2'b01, 4'b1000);

    // R5 R7: B rising-edge continuous on software source
    wr_ctrl(1, 8'h68);
    step(1);
    wr_sw(2'b10);
    step(1);
    expect_out("R5 R7 sw edge starts B", 2'b11, 4'b0010);
    wr_sw(2'b00);
    step(2);
    expect_out("R5 runs after sw drop", 2'b11, 4'b0000);
    wr_sw(2'b10);
    step(2);
    expect_out("R5 ignores later edge", 2'b11, 4'b0010);
    lock = 2'b01;
    step(1);
    expect_out("R6 unlock stops B", 2'b01, 4'b0010);
    lock = 2'b11;
    step(2);
    expect_out("R6 relock no restart", 2'b01, 4'b0010);

    // R7: both software triggers at once
    wr_ctrl(0, 8'h08);
    wr_sw(2'b00);
    step(1);
    wr_sw(2'b11);
    step(1);
    expect_out("R7 sw both channels", 2'b11, 4'b0011);

    // R9: reserved codes
    wr_ctrl(0, 8'h19);
    step(2);
    expect_out("R9 reserved source", 2'b10, 4'b0011);
    wr_ctrl(0, 8'h40);
    front_in = 1'b1;
    step(3);
    expect_out("R9 reserved mode 4", 2'b10, 4'b0111);
    wr_ctrl(0, 8'h86);
    step(2);
    expect_out("R9 reserved mode 8", 2'b10, 4'b0011);
    front_in = 1'b0;

    // R1: star source code 7
    wr_ctrl(0, 8'h07);
    star_in = 1'b1;
    step(3);
    expect_out("R1 star level", 2'b11, 4'b0111);

    // R11: control write clears run
    wr_ctrl(0, 8'h07);
    expect_out("R11 write clears run", 2'b10, 4'b0111);
    step(1);
    expect_out("R11 level resumes", 2'b11, 4'b0111);

    // R6 R13: unlock A only
    lock = 2'b10;
    step(1);
    expect_out("R6 R13 A stops B runs", 2'b10, 4'b0111);
    lock = 2'b11;
    step(1);
    expect_out("R6 A level resumes", 2'b11, 4'b0111);

    // R11: active source at write is not an edge
    wr_ctrl(0, 8'h27);
    step(3);
    expect_out("R11 active source not an edge", 2'b10, 4'b0111);
    star_in = 1'b0;
    step(3);
    expect_out("R11 fall no toggle", 2'b10, 4'b0011);
    star_in = 1'b1;
    step(3);
    expect_out("R4 R11 fresh rise toggles", 2'b11, 4'b0111);

    step(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule